// File: doc/BRIEF.md
# Shared-Slave Bus Arbiter for Three Masters

This block chooses which of three AHB-Lite style masters may drive a single shared slave port. The three masters are the instruction fetch path (port 0), the data path (port 1) and the system path (port 2). Each master raises a request line. The arbiter watches the transfer currently on the shared bus: the slave ready signal, the transfer type and the burst type. It returns a registered one-hot grant together with the binary index of the granted master, and the surrounding address and control multiplexer uses that index to select a master.

A static mode pin selects one of two schemes. In fixed-priority mode, a lower port index always wins. In round-robin mode, the search starts at the port after the current owner. A new decision is taken only on a cycle where the slave reports ready. It is also blocked while a fixed-length burst still has address beats to issue, so a four-, eight- or sixteen-beat burst is never split. Undefined-length bursts and single transfers may be cut at any ready beat.

The arbiter has no valid/ready stream of its own. All of its pins are plain control levels, so it applies no back-pressure. The slave's ready signal gates when the arbiter acts and does not form a handshake with it.

Top module: `ahb_bus_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the grant is 3'b001 and the index is 0.
- R2: Exactly one grant bit is high on every cycle, and the grant index always names that bit.
- R3: The grant changes only at a clock edge where the bus ready input was high in the cycle before that edge. A cycle with ready low leaves grant and index unchanged, whatever the request lines do.
- R4: In fixed mode (mode pin 0), an arbitration cycle hands the grant to the lowest-numbered requesting port.
- R5: In fixed mode, an arbitration cycle with no request parks the grant on port 0.
- R6: In round-robin mode (mode pin 1), an arbitration cycle hands the grant to the first requesting port found while counting upward from the owner's index plus one and wrapping past port 2. The owner keeps the grant only if no other port requests.
- R7: In round-robin mode, an arbitration cycle with no request leaves the grant on the current owner.
- R8: A ready beat is a fixed-length burst start when the transfer type is 2'b10 (first beat) and the burst code is 2 or 3 (4 beats), 4 or 5 (8 beats), or 6 or 7 (16 beats). For such a start the grant is held until the last beat of that burst has been accepted, where each following beat is a ready cycle with transfer type 2'b11. The grant may change at the edge that accepts the last beat.
- R9: A first beat with burst code 0 (single) or 1 (undefined length), and any sequential beat of an undefined-length burst, leaves the bus open for arbitration on that ready beat.
- R10: Ready cycles with transfer type 2'b01 (busy) or 2'b00 (idle) do not use up beats of an ongoing fixed-length burst. The grant stays locked through them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_mode | input | 1 | 0 selects fixed priority, 1 selects round-robin |
| req | input | 3 | Request lines: bit 0 instruction, bit 1 data, bit 2 system |
| hready | input | 1 | Shared-bus ready; high marks a completed beat |
| htrans | input | 2 | Transfer type on the shared bus (00 idle, 01 busy, 10 first, 11 sequential) |
| hburst | input | 3 | Burst type on the shared bus |
| grant | output | 3 | Registered one-hot grant |
| grant_idx | output | 2 | Binary index of the granted port |

## Verification
The checker verifies on every cycle:
- the grant is one-hot and the index agrees with it;
- the grant is frozen while ready is low;
- a fixed-length burst start never releases the grant;
- in fixed mode, an open arbitration cycle sends the grant to port 0 whenever port 0 requests or nothing requests;
- in round-robin mode, an open cycle with no request keeps the grant on the owner.

Some behaviour depends on history that a short property cannot capture. This covers the exact handover beat at the end of 4-beat bursts, how busy and idle beats inside a burst are counted, the rotation order across several consecutive grants, and re-arbitration inside undefined-length bursts. Only the bench's scenarios show these, through its beat-by-beat reference model.

// File: rtl/ahb_arb_pkg.sv
package ahb_arb_pkg;

  // Longest fixed-length burst the tracker must hold the bus for.
  localparam int MAX_BEATS = 16;
  localparam int BEAT_W    = $clog2(MAX_BEATS + 1);

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  // Number of address beats implied by a burst code; 1 for single and
  // undefined-length bursts, which never lock the bus.
  function automatic logic [BEAT_W-1:0] burst_beats(input logic [2:0] code);
    logic [BEAT_W-1:0] n;
    case (code)
      3'd2, 3'd3: n = BEAT_W'(4);
      3'd4, 3'd5: n = BEAT_W'(8);
      3'd6, 3'd7: n = BEAT_W'(16);
      default:    n = BEAT_W'(1);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/ahb_arb_burst_track.sv
module ahb_arb_burst_track
  import ahb_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hready,
  input  logic [1:0] htrans,
  input  logic [2:0] hburst,
  output logic       arb_open
);

  // Beats of the current fixed-length burst still to be issued.
  logic [BEAT_W-1:0] left_q;
  logic [BEAT_W-1:0] left_next;
  trans_e            kind;

  assign kind = trans_e'(htrans);

  always_comb begin
    left_next = left_q;
    if (hready) begin
      case (kind)
        TR_NONSEQ: left_next = burst_beats(hburst) - BEAT_W'(1);
        TR_SEQ:    left_next = (left_q == '0) ? '0 : left_q - BEAT_W'(1);
        default:   left_next = left_q;
      endcase
    end
  end

  assign arb_open = hready && (left_next == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (hready) begin
      left_q <= left_next;
    end
  end

endmodule

// File: rtl/ahb_arb_pick.sv
module ahb_arb_pick #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic             rr_mode,
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] owner_idx,
  output logic [IDX_W-1:0] pick_idx
);

  logic [IDX_W-1:0] fix_idx;
  logic [IDX_W-1:0] rot_idx;
  int               cand;

  // Fixed priority: scan downward so the lowest requesting index lands last.
  always_comb begin
    fix_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) fix_idx = IDX_W'(i);
    end
  end

  // Rotating priority: scan offsets from N down to 1 so the nearest
  // requester after the owner lands last; offset N is the owner itself.
  always_comb begin
    rot_idx = owner_idx;
    cand    = 0;
    for (int k = N; k >= 1; k--) begin
      cand = int'(owner_idx) + k;
      if (cand >= N) cand = cand - N;
      if (req[IDX_W'(cand)]) rot_idx = IDX_W'(cand);
    end
  end

  assign pick_idx = rr_mode ? rot_idx : fix_idx;

endmodule

// File: rtl/ahb_arb_onehot.sv
module ahb_arb_onehot #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0] idx,
  output logic [N-1:0]     vec
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign vec[g] = (idx == IDX_W'(g));
  end

endmodule

// File: rtl/ahb_bus_arbiter.sv
module ahb_bus_arbiter #(
  parameter int NUM_MASTERS = 3,
  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rr_mode,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic                   hready,
  input  logic [1:0]             htrans,
  input  logic [2:0]             hburst,
  output logic [NUM_MASTERS-1:0] grant,
  output logic [IDX_W-1:0]       grant_idx
);

  logic                   arb_open;
  logic [IDX_W-1:0]       pick_idx;
  logic [IDX_W-1:0]       owner_q;
  logic [NUM_MASTERS-1:0] pick_vec;
  logic [NUM_MASTERS-1:0] grant_q;

  ahb_arb_burst_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .hready   (hready),
    .htrans   (htrans),
    .hburst   (hburst),
    .arb_open (arb_open)
  );

  ahb_arb_pick #(.N(NUM_MASTERS), .IDX_W(IDX_W)) u_pick (
    .rr_mode   (rr_mode),
    .req       (req),
    .owner_idx (owner_q),
    .pick_idx  (pick_idx)
  );

  ahb_arb_onehot #(.N(NUM_MASTERS), .IDX_W(IDX_W)) u_dec (
    .idx (pick_idx),
    .vec (pick_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q <= '0;
      grant_q <= NUM_MASTERS'(1);
    end else if (arb_open) begin
      owner_q <= pick_idx;
      grant_q <= pick_vec;
    end
  end

  assign grant     = grant_q;
  assign grant_idx = owner_q;

endmodule

// File: rtl/ahb_bus_arbiter_chk.sv
module ahb_bus_arbiter_chk #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rr_mode,
  input logic [N-1:0]     req,
  input logic             hready,
  input logic [1:0]       htrans,
  input logic [2:0]       hburst,
  input logic [N-1:0]     grant,
  input logic [IDX_W-1:0] grant_idx,
  input logic             arb_open
);

  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == 1);

  p_idx_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant[grant_idx] == 1'b1);

  p_hold_unready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> ($stable(grant) && $stable(grant_idx)));

  p_fixed_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_open && !rr_mode && req[0]) |=> grant[0]);

  p_fixed_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_open && !rr_mode && req == '0) |=> grant[0]);

  p_rr_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_open && rr_mode && req == '0) |=> $stable(grant));

  p_burst_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && htrans == 2'b10 && hburst >= 3'd2) |=> $stable(grant));

endmodule

bind ahb_bus_arbiter ahb_bus_arbiter_chk #(.N(NUM_MASTERS), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rr_mode   (rr_mode),
  .req       (req),
  .hready    (hready),
  .htrans    (htrans),
  .hburst    (hburst),
  .grant     (grant),
  .grant_idx (grant_idx),
  .arb_open  (arb_open)
);

// File: tb/ahb_bus_arbiter_bench.sv
`timescale 1ns/1ps
module ahb_bus_arbiter_bench;

  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rr_mode = 1'b0;
  logic [N-1:0] req = '0;
  logic         hready = 1'b1;
  logic [1:0]   htrans = 2'b00;
  logic [2:0]   hburst = 3'd0;
  logic [N-1:0] grant;
  logic [1:0]   grant_idx;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string tag    = "R1";

  // Behavioural reference state.
  int m_owner = 0;
  int m_left  = 0;

  always #4 clk = ~clk;

  ahb_bus_arbiter u_ahb_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .req(req),
    .hready(hready), .htrans(htrans), .hburst(hburst),
    .grant(grant), .grant_idx(grant_idx)
  );

  function automatic int beats(input logic [2:0] b);
    if (b == 3'd2 || b == 3'd3) return 4;
    if (b == 3'd4 || b == 3'd5) return 8;
    if (b == 3'd6 || b == 3'd7) return 16;
    return 1;
  endfunction

  function automatic int choose(input int owner, input logic [N-1:0] r, input logic rr);
    if (!rr) begin
      for (int i = 0; i < N; i++) if (r[i]) return i;
      return 0;
    end
    for (int k = 1; k <= N; k++) if (r[(owner + k) % N]) return (owner + k) % N;
    return owner;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_owner = 0;
      m_left  = 0;
    end else if (hready) begin
      int rem;
      rem = m_left;
      if (htrans == 2'b10) rem = beats(hburst) - 1;
      else if (htrans == 2'b11) rem = (m_left > 0) ? m_left - 1 : 0;
      if (rem == 0) m_owner = choose(m_owner, req, rr_mode);
      m_left = rem;
    end
  end

  task automatic check_now();
    logic [N-1:0] exp_g;
    exp_g = N'(1) << m_owner;
    checks++;
    if (grant !== exp_g) begin
      fails++;
      $display("FAIL %s grant actual=%b expected=%b at %0t", tag, grant, exp_g, $time);
    end
    checks++;
    if (grant_idx !== 2'(m_owner)) begin
      fails++;
      $display("FAIL R2 grant_idx actual=%0d expected=%0d (%s) at %0t", grant_idx, m_owner, tag, $time);
    end
    checks++;
    if ($countones(grant) != 1) begin
      fails++;
      $display("FAIL R2 onehot actual=%b expected=one bit at %0t", grant, $time);
    end
  endtask

  task automatic step(input logic m, input logic [N-1:0] r, input logic rdy,
                      input logic [1:0] t, input logic [2:0] b, input string tg);
    @(negedge clk);
    check_now();
    rr_mode = m; req = r; hready = rdy; htrans = t; hburst = b; tag = tg;
  endtask

  initial begin
    // R1: reset holds grant on port 0
    tag = "R1";
    repeat (3) step(1'b0, 3'b110, 1'b1, 2'b00, 3'd0, "R1");
    @(negedge clk); check_now(); rst_n = 1'b1; tag = "R1";
    step(1'b0, 3'b000, 1'b1, 2'b00, 3'd0, "R1");
    // R4: fixed priority picks lowest index
    step(1'b0, 3'b110, 1'b1, 2'b00, 3'd0, "R4");
    step(1'b0, 3'b111, 1'b1, 2'b00, 3'd0, "R4");
    step(1'b0, 3'b100, 1'b1, 2'b00, 3'd0, "R4");
    // R3: ready low freezes the grant
    step(1'b0, 3'b001, 1'b0, 2'b00, 3'd0, "R3");
    step(1'b0, 3'b010, 1'b0, 2'b10, 3'd0, "R3");
    step(1'b0, 3'b010, 1'b1, 2'b00, 3'd0, "R3");
    // R5: no request parks on port 0
    step(1'b0, 3'b000, 1'b1, 2'b00, 3'd0, "R5");
    step(1'b0, 3'b100, 1'b1, 2'b00, 3'd0, "R5");
    step(1'b0, 3'b000, 1'b1, 2'b00, 3'd0, "R5");
    // R6: rotation after owner
    for (int i = 0; i < 4; i++) step(1'b1, 3'b111, 1'b1, 2'b00, 3'd0, "R6");
    step(1'b1, 3'b101, 1'b1, 2'b00, 3'd0, "R6");
    step(1'b1, 3'b101, 1'b1, 2'b00, 3'd0, "R6");
    step(1'b1, 3'b001, 1'b1, 2'b00, 3'd0, "R6");
    step(1'b1, 3'b001, 1'b1, 2'b00, 3'd0, "R6");
    // R7: round-robin park on owner
    step(1'b1, 3'b010, 1'b1, 2'b00, 3'd0, "R7");
    step(1'b1, 3'b000, 1'b1, 2'b00, 3'd0, "R7");
    step(1'b1, 3'b000, 1'b1, 2'b00, 3'd0, "R7");
    // R8: 4-beat incrementing burst, then 8-beat wrapping burst
    step(1'b1, 3'b111, 1'b1, 2'b10, 3'd3, "R8");
    for (int i = 0; i < 3; i++) step(1'b1, 3'b111, 1'b1, 2'b11, 3'd3, "R8");
    step(1'b1, 3'b111, 1'b1, 2'b10, 3'd4, "R8");
    for (int i = 0; i < 7; i++) step(1'b1, 3'b111, 1'b1, 2'b11, 3'd4, "R8");
    step(1'b0, 3'b111, 1'b1, 2'b10, 3'd7, "R8");
    for (int i = 0; i < 15; i++) step(1'b0, 3'b111, 1'b1, 2'b11, 3'd7, "R8");
    // R10: busy and idle beats and stalls inside a burst
    step(1'b1, 3'b110, 1'b1, 2'b10, 3'd2, "R10");
    step(1'b1, 3'b110, 1'b1, 2'b01, 3'd2, "R10");
    step(1'b1, 3'b110, 1'b1, 2'b11, 3'd2, "R10");
    step(1'b1, 3'b110, 1'b0, 2'b11, 3'd2, "R10");
    step(1'b1, 3'b110, 1'b1, 2'b11, 3'd2, "R10");
    step(1'b1, 3'b110, 1'b1, 2'b00, 3'd2, "R10");
    step(1'b1, 3'b110, 1'b1, 2'b11, 3'd2, "R10");
    step(1'b1, 3'b110, 1'b1, 2'b00, 3'd0, "R10");
    // R9: single and undefined-length transfers re-arbitrate each beat
    step(1'b1, 3'b111, 1'b1, 2'b10, 3'd1, "R9");
    step(1'b1, 3'b111, 1'b1, 2'b11, 3'd1, "R9");
    step(1'b1, 3'b111, 1'b1, 2'b11, 3'd1, "R9");
    step(1'b0, 3'b110, 1'b1, 2'b10, 3'd0, "R9");
    step(1'b0, 3'b011, 1'b1, 2'b11, 3'd1, "R9");
    step(1'b0, 3'b000, 1'b1, 2'b00, 3'd0, "R9");
    @(negedge clk); check_now();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule